// File: doc/BRIEF.md
# Neighbour-Sum Victim Row Refresher

This block watches the row activate commands that a memory controller issues to one DRAM bank. It keeps a saturating activation count per row. The counts are valid for one counting window, whose length is set in clock cycles. A row is treated as a victim when the activations of the rows directly beside it add up to a programmable limit within that window. This covers both cases: one neighbour hammered alone, and both neighbours hammered together. The address of each victim is placed in a short queue. The queue offers the addresses, one at a time, to a refresh issuer through a valid/ready stream.

The output stream follows the usual back-pressure rules. While `vic_valid` is high and `vic_ready` is low, the head address stays fixed, and nothing is lost or reordered. An address leaves the queue only in a cycle where valid and ready are both high. That grant also tells the block that the victim has been refreshed, so the counts of its neighbours start again from zero.

When the attached module cannot take targeted refreshes, the integrator drives `trr_enable` low. The block then stops queuing victims and raises `dbl_refresh`, which asks the refresh scheduler to run ordinary refresh at twice its normal rate.

Top module: `rh_victim_refresher`

## Requirements
- R1: Each activate increments the count of the addressed row by one. The count saturates at all ones (255 with the default 8-bit count) and never wraps.
- R2: After an activate of row r, row r-1 is flagged if count[r-2] + count[r] >= `max_act`, and row r+1 is flagged if count[r] + count[r+2] >= `max_act`. All counts used here already include that activate. A single row reaching `max_act` therefore flags both of its neighbours.
- R3: Activations on the two rows either side of a victim add together. For example, two activates each on rows 3 and 5 flag row 4 when `max_act` is 4.
- R4: Row 0 has only row 1 as a neighbour, and the top row has only the row below it. No victim address wraps around the ends of the bank.
- R5: The window timer runs for `window_len` cycles from reset and then restarts at once. At each restart all counts clear. An activate in the last cycle of a window counts as 1 in the new window.
- R6: Victims wait in a 4-entry FIFO. When both neighbours are flagged in the same cycle, the lower address is queued first. A victim that finds the FIFO full is dropped, and it is flagged again by a later activate while the neighbour sum still meets the limit.
- R7: An address already waiting in the FIFO is not queued a second time.
- R8: While `vic_valid` is high and `vic_ready` is low, `vic_valid` stays high and `vic_row` does not change.
- R9: A grant (`vic_valid` and `vic_ready` both high) removes the head entry and clears the counts of the two rows beside that victim.
- R10: While `trr_enable` is low, no victim is queued, but counting continues. `dbl_refresh` equals the inverse of `trr_enable`, delayed by one cycle.
- R11: After reset, `vic_valid` and `dbl_refresh` are low and all counts are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | An activate command is issued this cycle |
| act_row | input | ROW_W (4) | Row address of the activate |
| max_act | input | CNT_W (8) | Limit on the neighbour activation sum |
| window_len | input | WIN_W (16) | Counting window length in cycles |
| trr_enable | input | 1 | Targeted refresh is supported by the module |
| vic_valid | output | 1 | A victim address is offered |
| vic_ready | input | 1 | The refresh issuer accepts the offered victim |
| vic_row | output | ROW_W (4) | Victim row address |
| dbl_refresh | output | 1 | Request for regular refresh at twice the normal rate |

## Verification
The hardest cases to reach from the ports are those where counting and queue state interact. One is a count that must go past its saturation point without being cleared by a grant along the way. To reach it, the bench hammers one row 300 times with targeted refresh disabled, then re-enables it. A single activate on the neighbour two rows up must then flag the row in between, which only happens if the count held at 255. The full-queue drop is reached by holding `vic_ready` low while three aggressors are hammered. A later activate must then bring the dropped victims back. The window restart is checked by timing activates relative to reset, so that a sum which would meet the limit is split across two windows.

// File: rtl/rh_pkg.sv
package rh_pkg;
  localparam int DEF_ROWS   = 16;
  localparam int DEF_CNT_W  = 8;
  localparam int DEF_WIN_W  = 16;
  localparam int DEF_QDEPTH = 4;
endpackage

// File: rtl/rh_window_timer.sv
module rh_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len,
  output logic             expire
);
  logic [WIN_W-1:0] tmr;

  // A window of length 0 behaves like length 1.
  assign expire = ({1'b0, tmr} + (WIN_W+1)'(1)) >= {1'b0, win_len};

  always_ff @(posedge clk) begin
    if (!rst_n)      tmr <= '0;
    else if (expire) tmr <= '0;
    else             tmr <= tmr + WIN_W'(1);
  end
endmodule

// File: rtl/rh_row_counters.sv
module rh_row_counters #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 4,
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_valid,
  input  logic [ROW_W-1:0]           act_row,
  input  logic                       clear_all,
  input  logic [ROWS-1:0]            clr_mask,
  output logic [ROWS-1:0][CNT_W-1:0] cnt_q,
  output logic [ROWS-1:0][CNT_W-1:0] cnt_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic [CNT_W-1:0] base;
    logic             hit;
    assign base = (clear_all || clr_mask[i]) ? '0 : cnt_q[i];
    assign hit  = act_valid && (act_row == ROW_W'(i));
    assign cnt_n[i] = (hit && base != CNT_MAX) ? base + CNT_W'(1) : base;

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[i] <= '0;
      else        cnt_q[i] <= cnt_n[i];
    end
  end
endmodule

// File: rtl/rh_victim_detect.sv
module rh_victim_detect #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 4,
  parameter int CNT_W = 8
) (
  input  logic                       en,
  input  logic [ROW_W-1:0]           act_row,
  input  logic [ROWS-1:0][CNT_W-1:0] cnt_n,
  input  logic [CNT_W-1:0]           max_act,
  output logic                       lo_hit,
  output logic [ROW_W-1:0]           lo_row,
  output logic                       hi_hit,
  output logic [ROW_W-1:0]           hi_row
);
  logic [CNT_W:0] own, far_lo, far_hi, limit;

  always_comb begin
    own    = {1'b0, cnt_n[act_row]};
    far_lo = (int'(act_row) >= 2) ? {1'b0, cnt_n[act_row - ROW_W'(2)]} : '0;
    far_hi = (int'(act_row) + 2 < ROWS) ? {1'b0, cnt_n[act_row + ROW_W'(2)]} : '0;
    limit  = {1'b0, max_act};
    lo_hit = en && (int'(act_row) > 0) && ((own + far_lo) >= limit);
    hi_hit = en && (int'(act_row) < ROWS - 1) && ((own + far_hi) >= limit);
    lo_row = act_row - ROW_W'(1);
    hi_row = act_row + ROW_W'(1);
  end
endmodule

// File: rtl/rh_victim_queue.sv
module rh_victim_queue #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 4,
  parameter int QCW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_a,
  input  logic [ROW_W-1:0] row_a,
  input  logic             push_b,
  input  logic [ROW_W-1:0] row_b,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [ROW_W-1:0] out_row,
  output logic [QCW-1:0]   occupancy
);
  logic [ROW_W-1:0] ent     [DEPTH];
  logic [ROW_W-1:0] nxt_ent [DEPTH];
  logic [QCW-1:0]   cnt, nxt_cnt;
  logic             pop, dup_a, dup_b;

  assign out_valid = (cnt != '0);
  assign out_row   = ent[0];
  assign occupancy = cnt;
  assign pop       = out_valid && out_ready;

  always_comb begin
    nxt_ent = ent;
    nxt_cnt = cnt;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) nxt_ent[i] = ent[i+1];
      nxt_cnt = cnt - QCW'(1);
    end
    dup_a = 1'b0;
    dup_b = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (QCW'(i) < nxt_cnt && nxt_ent[i] == row_a) dup_a = 1'b1;
      if (QCW'(i) < nxt_cnt && nxt_ent[i] == row_b) dup_b = 1'b1;
    end
    if (push_a && !dup_a && nxt_cnt < QCW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (QCW'(i) == nxt_cnt) nxt_ent[i] = row_a;
      nxt_cnt = nxt_cnt + QCW'(1);
    end
    if (push_b && !dup_b && nxt_cnt < QCW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (QCW'(i) == nxt_cnt) nxt_ent[i] = row_b;
      nxt_cnt = nxt_cnt + QCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      cnt <= nxt_cnt;
      ent <= nxt_ent;
    end
  end
endmodule

// File: rtl/rh_victim_refresher.sv
module rh_victim_refresher
  import rh_pkg::*;
#(
  parameter int ROWS   = DEF_ROWS,
  parameter int CNT_W  = DEF_CNT_W,
  parameter int WIN_W  = DEF_WIN_W,
  parameter int QDEPTH = DEF_QDEPTH,
  localparam int ROW_W = $clog2(ROWS),
  localparam int QCW   = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  logic [ROW_W-1:0] act_row,
  input  logic [CNT_W-1:0] max_act,
  input  logic [WIN_W-1:0] window_len,
  input  logic             trr_enable,
  output logic             vic_valid,
  input  logic             vic_ready,
  output logic [ROW_W-1:0] vic_row,
  output logic             dbl_refresh
);
  logic                       win_expire;
  logic [ROWS-1:0]            clr_mask;
  logic [ROWS-1:0][CNT_W-1:0] row_cnt, cnt_next;
  logic                       lo_hit, hi_hit;
  logic [ROW_W-1:0]           lo_row, hi_row;
  logic [QCW-1:0]             q_count;
  logic                       grant;

  assign grant = vic_valid && vic_ready;

  // A grant refreshes the head victim: clear the rows on either side of it.
  always_comb begin
    for (int i = 0; i < ROWS; i++)
      clr_mask[i] = grant && ((int'(vic_row) == i + 1) || (int'(vic_row) + 1 == i));
  end

  rh_window_timer #(.WIN_W(WIN_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .win_len(window_len), .expire(win_expire)
  );

  rh_row_counters #(.ROWS(ROWS), .ROW_W(ROW_W), .CNT_W(CNT_W)) i_counters (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
    .clear_all(win_expire), .clr_mask(clr_mask), .cnt_q(row_cnt), .cnt_n(cnt_next)
  );

  rh_victim_detect #(.ROWS(ROWS), .ROW_W(ROW_W), .CNT_W(CNT_W)) i_detect (
    .en(act_valid && trr_enable), .act_row(act_row), .cnt_n(cnt_next),
    .max_act(max_act), .lo_hit(lo_hit), .lo_row(lo_row),
    .hi_hit(hi_hit), .hi_row(hi_row)
  );

  rh_victim_queue #(.DEPTH(QDEPTH), .ROW_W(ROW_W), .QCW(QCW)) i_queue (
    .clk(clk), .rst_n(rst_n),
    .push_a(lo_hit), .row_a(lo_row), .push_b(hi_hit), .row_b(hi_row),
    .out_ready(vic_ready), .out_valid(vic_valid), .out_row(vic_row),
    .occupancy(q_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dbl_refresh <= 1'b0;
    else        dbl_refresh <= !trr_enable;
  end
endmodule

// File: rtl/rh_victim_refresher_chk.sv
module rh_victim_refresher_chk #(
  parameter int ROWS   = 16,
  parameter int CNT_W  = 8,
  parameter int QDEPTH = 4,
  parameter int ROW_W  = 4,
  parameter int QCW    = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       act_valid,
  input logic                       trr_enable,
  input logic                       vic_valid,
  input logic                       vic_ready,
  input logic [ROW_W-1:0]           vic_row,
  input logic                       win_expire,
  input logic [ROWS-1:0]            clr_mask,
  input logic [ROWS-1:0][CNT_W-1:0] row_cnt,
  input logic [QCW-1:0]             q_count
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_row)));

  assert_no_queue_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trr_enable && !vic_valid) |=> !vic_valid);

  assert_queue_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QCW'(QDEPTH));

  assert_window_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_expire && !act_valid) |=> (row_cnt == '0));

  for (genvar i = 0; i < ROWS; i++) begin : g_mono
    assert_no_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_expire && !clr_mask[i]) |=> (row_cnt[i] >= $past(row_cnt[i])));
  end
endmodule

bind rh_victim_refresher rh_victim_refresher_chk #(
  .ROWS(ROWS), .CNT_W(CNT_W), .QDEPTH(QDEPTH), .ROW_W(ROW_W), .QCW(QCW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .trr_enable(trr_enable),
  .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_row(vic_row),
  .win_expire(win_expire), .clr_mask(clr_mask), .row_cnt(row_cnt),
  .q_count(q_count)
);

// File: tb/test_rh_victim_refresher.sv
`timescale 1ns/1ps
module test_rh_victim_refresher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_valid = 1'b0;
  logic [3:0] act_row = '0;
  logic [7:0] max_act = 8'd4;
  logic [15:0] window_len = 16'hFFFF;
  logic       trr_enable = 1'b1;
  logic       vic_valid;
  logic       vic_ready = 1'b0;
  logic [3:0] vic_row;
  logic       dbl_refresh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rh_victim_refresher i_rh_victim_refresher (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
    .max_act(max_act), .window_len(window_len), .trr_enable(trr_enable),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_row(vic_row),
    .dbl_refresh(dbl_refresh)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; act_valid = 1'b0; vic_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic act(int row, int n);
    for (int k = 0; k < n; k++) begin
      act_valid = 1'b1;
      act_row = 4'(row);
      @(negedge clk);
      act_valid = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_expect(string req, int row);
    check({req, " valid"}, int'(vic_valid), 1);
    check({req, " row"}, int'(vic_row), row);
    vic_ready = 1'b1;
    @(negedge clk);
    vic_ready = 1'b0;
  endtask

  task automatic expect_empty(string req);
    check({req, " empty"}, int'(vic_valid), 0);
  endtask

  task automatic t_reset();
    window_len = 16'hFFFF; trr_enable = 1'b1; max_act = 8'd4;
    do_reset();
    check("R11 vic_valid", int'(vic_valid), 0);
    check("R11 dbl_refresh", int'(dbl_refresh), 0);
  endtask

  task automatic t_single_hold();
    do_reset();
    act(7, 3);
    expect_empty("R2 below limit");
    act(7, 1);
    for (int k = 0; k < 3; k++) begin
      check("R8 held valid", int'(vic_valid), 1);
      check("R8 held row", int'(vic_row), 6);
      @(negedge clk);
    end
    pop_expect("R2 R6 lower first", 6);
    pop_expect("R2 upper", 8);
    expect_empty("R2 drained");
  endtask

  task automatic t_double_sided();
    do_reset();
    act(3, 1); act(5, 1); act(3, 1);
    expect_empty("R3 sum 3");
    act(5, 1);
    pop_expect("R3 sandwiched victim", 4);
    expect_empty("R3 only one victim");
    act(3, 1);
    expect_empty("R9 aggressors cleared on grant");
  endtask

  task automatic t_edges();
    do_reset();
    act(0, 4);
    pop_expect("R4 bottom row", 1);
    expect_empty("R4 no wrap low");
    do_reset();
    act(15, 4);
    pop_expect("R4 top row", 14);
    expect_empty("R4 no wrap high");
  endtask

  task automatic t_full_dedup();
    do_reset();
    act(2, 4);
    act(2, 1);
    act(10, 4);
    act(13, 4);
    pop_expect("R7 first", 1);
    pop_expect("R7 second", 3);
    pop_expect("R7 no duplicate", 9);
    pop_expect("R6 fourth", 11);
    expect_empty("R6 full drops");
    act(13, 1);
    pop_expect("R6 reflag low", 12);
    pop_expect("R6 reflag high", 14);
    expect_empty("R6 drained");
  endtask

  task automatic t_window();
    window_len = 16'd40;
    do_reset();
    act(5, 3);
    idle(41);
    act(5, 3);
    expect_empty("R5 window cleared");
    act(5, 1);
    pop_expect("R5 new window low", 4);
    pop_expect("R5 new window high", 6);
    window_len = 16'hFFFF;
  endtask

  task automatic t_saturate_fallback();
    max_act = 8'd255;
    do_reset();
    trr_enable = 1'b0;
    idle(1);
    check("R10 dbl_refresh on", int'(dbl_refresh), 1);
    act(7, 300);
    expect_empty("R10 nothing queued when off");
    trr_enable = 1'b1;
    idle(1);
    check("R10 dbl_refresh off", int'(dbl_refresh), 0);
    act(9, 1);
    pop_expect("R1 saturated count", 8);
    expect_empty("R1 single victim");
    max_act = 8'd4;
  endtask

  initial begin
    t_reset();
    t_single_hold();
    t_double_sided();
    t_edges();
    t_full_dedup();
    t_window();
    t_saturate_fallback();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule